// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a load/store RISC datapath. It is purely combinational. Each operand passes through it once, and the result and shifter carry-out are valid in the same cycle as the inputs. The operand comes from a register. The shift amount comes from an immediate field or from a second register, and the surrounding decode logic chooses which. The current carry flag is fed in so that zero-length shifts and the one-bit rotate through carry can use it.

Five operations are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through carry. Only the low byte of the amount input counts. Each operation defines its carry-out separately for four amount ranges: zero, inside the word, exactly the word width, and beyond it. The ALU and the flag register sit outside the block. A parameter selects either a logarithmic stage-per-bit network or a flat operator-based shift; both variants behave identically at the ports.

Top module: `barrel_shift_cy`

## Requirements
- R1: The 3-bit `kind` input selects the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 one-bit rotate right through carry.
- R2: Only `amount[7:0]` is used; bits 31..8 of `amount` have no effect on `result` or `carry_out`.
- R3: For kinds 0 to 3 with an amount of zero, `result` equals `data_in` and `carry_out` equals `carry_in`.
- R4: Logical left by n in 1..32 gives `data_in << n` with `carry_out = data_in[32-n]`; at n = 32 the result is 0 and the carry is `data_in[0]`.
- R5: Logical right by n in 1..32 gives `data_in >> n` with `carry_out = data_in[n-1]`; at n = 32 the result is 0 and the carry is `data_in[31]`.
- R6: Logical left or logical right by n in 33..255 gives a result of 0 and a `carry_out` of 0.
- R7: Arithmetic right by n in 1..31 fills the vacated upper bits with `data_in[31]`, and `carry_out = data_in[n-1]`.
- R8: Arithmetic right by n in 32..255 makes every result bit and `carry_out` equal to `data_in[31]`.
- R9: Rotate right by a nonzero n rotates by n mod 32, and `carry_out` equals `result[31]`. For a nonzero multiple of 32, the result is `data_in` and the carry is `data_in[31]`.
- R10: Kind 4 gives `{carry_in, data_in[31:1]}` and `carry_out = data_in[0]`, whatever the amount.
- R11: Kind codes 5, 6 and 7 pass `data_in` through unchanged and keep `carry_in` as `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Operand to be shifted |
| kind | input | 3 | Operation select (see R1) |
| amount | input | 32 | Shift amount; only the low byte is used |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The hardest cases to reach are the range edges, where the carry source moves. These are amounts 31, 32 and 33, amounts that are multiples of 32 for rotation, and amounts whose low byte sits at one of these edges while the upper bits are nonzero. Random amounts almost never land on these values. The stimulus therefore sweeps every amount from 0 to 40 plus selected large values, for all eight kind codes, against operand patterns whose bits differ around each carry source (alternating bits, a lone sign bit, a lone low bit). Directed cases with both carry-in values show that a retained carry really comes from the input.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_t;
endpackage

// File: rtl/shf_amt_decode.sv
// Classifies the used low bits of the shift amount into ranges and produces
// a clamped count (0..DATA_W) for the linear shifters and a modulo count for rotation.
module shf_amt_decode #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned USE_W  = 8,
   localparam int unsigned CNT_W = $clog2(DATA_W) + 1,
   localparam int unsigned ROT_W = $clog2(DATA_W)
) (
   input  logic [USE_W-1:0] amt_lo,
   output logic             amt_zero,
   output logic             amt_over,
   output logic             amt_full,
   output logic [CNT_W-1:0] cnt_clamp,
   output logic [ROT_W-1:0] cnt_rot
);
   localparam logic [USE_W-1:0] W_AMT = USE_W'(DATA_W);
   localparam logic [CNT_W-1:0] W_CNT = CNT_W'(DATA_W);

   assign amt_zero  = (amt_lo == '0);
   assign amt_over  = (amt_lo > W_AMT);
   assign amt_full  = (amt_lo >= W_AMT);
   assign cnt_clamp = amt_full ? W_CNT : amt_lo[CNT_W-1:0];
   assign cnt_rot   = amt_lo[ROT_W-1:0];
endmodule

// File: rtl/shf_left_core.sv
// Left shift of {0, din} by cnt (0..DATA_W); bit DATA_W of ext is the last bit out.
module shf_left_core #(
   parameter int unsigned DATA_W = 32,
   parameter bit          STAGED = 1'b1,
   localparam int unsigned CNT_W = $clog2(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W:0]   ext
);
   generate
      if (STAGED) begin : g_log
         logic [DATA_W:0] stg [0:CNT_W];
         assign stg[0] = {1'b0, din};
         for (genvar k = 0; k < CNT_W; k++) begin : g_st
            localparam int unsigned SH = 1 << k;
            assign stg[k+1] = cnt[k] ? {stg[k][DATA_W-SH:0], {SH{1'b0}}} : stg[k];
         end
         assign ext = stg[CNT_W];
      end else begin : g_flat
         assign ext = {1'b0, din} << cnt;
      end
   endgenerate
endmodule

// File: rtl/shf_right_core.sv
// Right shift of {din, 0} by cnt (0..DATA_W) with a fill bit; bit 0 of ext is the last bit out.
module shf_right_core #(
   parameter int unsigned DATA_W = 32,
   parameter bit          STAGED = 1'b1,
   localparam int unsigned CNT_W = $clog2(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] din,
   input  logic              fill,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W:0]   ext
);
   generate
      if (STAGED) begin : g_log
         logic [DATA_W:0] stg [0:CNT_W];
         assign stg[0] = {din, 1'b0};
         for (genvar k = 0; k < CNT_W; k++) begin : g_st
            localparam int unsigned SH = 1 << k;
            assign stg[k+1] = cnt[k] ? {{SH{fill}}, stg[k][DATA_W:SH]} : stg[k];
         end
         assign ext = stg[CNT_W];
      end else begin : g_flat
         logic [DATA_W-1:0] wide_unused;
         assign {wide_unused, ext} = {{DATA_W{fill}}, din, 1'b0} >> cnt;
      end
   endgenerate
endmodule

// File: rtl/shf_rot_core.sv
// Rotate right by cnt (0..DATA_W-1).
module shf_rot_core #(
   parameter int unsigned DATA_W = 32,
   parameter bit          STAGED = 1'b1,
   localparam int unsigned ROT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [ROT_W-1:0]  cnt,
   output logic [DATA_W-1:0] dout
);
   generate
      if (STAGED) begin : g_log
         logic [DATA_W-1:0] stg [0:ROT_W];
         assign stg[0] = din;
         for (genvar k = 0; k < ROT_W; k++) begin : g_st
            localparam int unsigned SH = 1 << k;
            assign stg[k+1] = cnt[k] ? {stg[k][SH-1:0], stg[k][DATA_W-1:SH]} : stg[k];
         end
         assign dout = stg[ROT_W];
      end else begin : g_flat
         logic [DATA_W-1:0] wide_unused;
         assign {wide_unused, dout} = {din, din} >> cnt;
      end
   endgenerate
endmodule

// File: rtl/barrel_shift_cy.sv
module barrel_shift_cy #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned AMT_W  = 32,
   parameter int unsigned USE_W  = 8,
   parameter bit          STAGED = 1'b1
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [2:0]        kind,
   input  logic [AMT_W-1:0]  amount,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              carry_out
);
   import shf_pkg::*;

   localparam int unsigned CNT_W = $clog2(DATA_W) + 1;
   localparam int unsigned ROT_W = $clog2(DATA_W);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 8");
      end
      if (AMT_W < USE_W) begin : g_bad_amt
         $error("AMT_W must be at least USE_W");
      end
      if ((64'd1 << USE_W) <= 64'(DATA_W)) begin : g_bad_use
         $error("USE_W must be able to express amounts above DATA_W");
      end
      if (AMT_W > USE_W) begin : g_hi
         logic amt_unused_hi;
         assign amt_unused_hi = ^amount[AMT_W-1:USE_W];
      end
   endgenerate

   logic             a_zero, a_over, a_full;
   logic [CNT_W-1:0] c_lin;
   logic [ROT_W-1:0] c_rot;
   logic [DATA_W:0]  left_ext, right_ext;
   logic [DATA_W-1:0] rot_val;
   logic             sign_fill;

   shf_amt_decode #(.DATA_W(DATA_W), .USE_W(USE_W)) u_dec (
      .amt_lo   (amount[USE_W-1:0]),
      .amt_zero (a_zero),
      .amt_over (a_over),
      .amt_full (a_full),
      .cnt_clamp(c_lin),
      .cnt_rot  (c_rot)
   );

   shf_left_core #(.DATA_W(DATA_W), .STAGED(STAGED)) u_left (
      .din(data_in), .cnt(c_lin), .ext(left_ext)
   );

   assign sign_fill = (kind == SK_ASR) & data_in[DATA_W-1];

   shf_right_core #(.DATA_W(DATA_W), .STAGED(STAGED)) u_right (
      .din(data_in), .fill(sign_fill), .cnt(c_lin), .ext(right_ext)
   );

   shf_rot_core #(.DATA_W(DATA_W), .STAGED(STAGED)) u_rot (
      .din(data_in), .cnt(c_rot), .dout(rot_val)
   );

   always_comb begin
      result    = data_in;
      carry_out = carry_in;
      case (kind)
         SK_LSL: begin
            if (a_over) begin
               result    = '0;
               carry_out = 1'b0;
            end else if (!a_zero) begin
               {carry_out, result} = left_ext;
            end
         end
         SK_LSR: begin
            if (a_over) begin
               result    = '0;
               carry_out = 1'b0;
            end else if (!a_zero) begin
               {result, carry_out} = right_ext;
            end
         end
         SK_ASR: begin
            if (!a_zero) begin
               {result, carry_out} = right_ext;
            end
         end
         SK_ROR: begin
            if (!a_zero) begin
               result    = rot_val;
               carry_out = rot_val[DATA_W-1];
            end
         end
         SK_RRX: begin
            result    = {carry_in, data_in[DATA_W-1:1]};
            carry_out = data_in[0];
         end
         default: begin
            result    = data_in;
            carry_out = carry_in;
         end
      endcase
   end
endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned USE_W  = 8
) (
   input logic [DATA_W-1:0] data_in,
   input logic [2:0]        kind,
   input logic [USE_W-1:0]  amt_lo,
   input logic              carry_in,
   input logic [DATA_W-1:0] result,
   input logic              carry_out
);
   localparam logic [USE_W-1:0] W_AMT = USE_W'(DATA_W);

   logic known;
   assign known = !$isunknown({data_in, kind, amt_lo, carry_in, result, carry_out});

   always_comb begin
      if (known) begin
         if (kind <= 3'd3 && amt_lo == '0)
            assert_zero_pass_R3: assert (result == data_in && carry_out == carry_in);
         if (kind == 3'd0 && amt_lo == W_AMT)
            assert_lsl_edge_R4: assert (result == '0 && carry_out == data_in[0]);
         if (kind == 3'd1 && amt_lo == W_AMT)
            assert_lsr_edge_R5: assert (result == '0 && carry_out == data_in[DATA_W-1]);
         if ((kind == 3'd0 || kind == 3'd1) && amt_lo > W_AMT)
            assert_over_clear_R6: assert (result == '0 && !carry_out);
         if (kind == 3'd2 && amt_lo != '0)
            assert_asr_sign_R7: assert (result[DATA_W-1] == data_in[DATA_W-1]);
         if (kind == 3'd2 && amt_lo >= W_AMT)
            assert_asr_sat_R8: assert (result == {DATA_W{data_in[DATA_W-1]}}
                                       && carry_out == data_in[DATA_W-1]);
         if (kind == 3'd3 && amt_lo != '0)
            assert_ror_carry_R9: assert (carry_out == result[DATA_W-1]
                                         && $countones(result) == $countones(data_in));
         if (kind == 3'd4)
            assert_rrx_R10: assert ({result, carry_out} == {carry_in, data_in});
         if (kind >= 3'd5)
            assert_spare_R11: assert (result == data_in && carry_out == carry_in);
      end
   end
endmodule

bind barrel_shift_cy shf_checker #(.DATA_W(DATA_W), .USE_W(USE_W)) u_chk (
   .data_in  (data_in),
   .kind     (kind),
   .amt_lo   (amount[USE_W-1:0]),
   .carry_in (carry_in),
   .result   (result),
   .carry_out(carry_out)
);

// File: tb/sim_barrel_shift_cy.sv
module sim_barrel_shift_cy;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst;
   logic [31:0] d_i, a_i;
   logic [2:0]  k_i;
   logic        c_i;
   logic [31:0] res_o;
   logic        c_o;
   int n_chk = 0;
   int n_err = 0;

   barrel_shift_cy u0 (
      .data_in(d_i), .kind(k_i), .amount(a_i), .carry_in(c_i),
      .result(res_o), .carry_out(c_o)
   );

   // Expected value built bit by bit from the requirements.
   function automatic logic [32:0] expect_of(logic [2:0] k, logic [31:0] dv,
                                             logic [31:0] av, logic ci);
      int n = int'(av[7:0]);
      logic [31:0] r = dv;
      logic c = ci;
      case (k)
         3'd0: if (n > 32) begin r = '0; c = 1'b0; end
               else if (n != 0) begin
                  for (int i = 0; i < 32; i++) r[i] = (i >= n) ? dv[i-n] : 1'b0;
                  c = dv[32-n];
               end
         3'd1: if (n > 32) begin r = '0; c = 1'b0; end
               else if (n != 0) begin
                  for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? dv[i+n] : 1'b0;
                  c = dv[n-1];
               end
         3'd2: if (n != 0) begin
                  for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? dv[i+n] : dv[31];
                  c = (n >= 32) ? dv[31] : dv[n-1];
               end
         3'd3: if (n != 0) begin
                  for (int i = 0; i < 32; i++) r[i] = dv[(i + (n % 32)) % 32];
                  c = r[31];
               end
         3'd4: begin r = {ci, dv[31:1]}; c = dv[0]; end
         default: ;
      endcase
      return {c, r};
   endfunction

   task automatic apply_chk(string tag, logic [2:0] k, logic [31:0] dv, logic [31:0] av,
                            logic ci, logic [31:0] er, logic ec);
      @(posedge clk);
      #1;
      k_i = k; d_i = dv; a_i = av; c_i = ci;
      @(negedge clk);
      n_chk++;
      if (res_o !== er || c_o !== ec) begin
         n_err++;
         $display("FAIL %s kind=%0d d=%h amt=%h cin=%b: got res=%h c=%b, expected res=%h c=%b",
                  tag, k, dv, av, ci, res_o, c_o, er, ec);
      end
   endtask

   task automatic apply_ref(string tag, logic [2:0] k, logic [31:0] dv, logic [31:0] av, logic ci);
      logic [32:0] e = expect_of(k, dv, av, ci);
      apply_chk(tag, k, dv, av, ci, e[31:0], e[32]);
   endtask

   task automatic t_reset;
      @(negedge clk);
      n_chk++;
      if (res_o !== 32'h0 || c_o !== 1'b0) begin
         n_err++;
         $display("FAIL reset idle: got res=%h c=%b, expected res=00000000 c=0", res_o, c_o);
      end
   endtask

   task automatic t_zero_R3;
      for (int k = 0; k < 4; k++) begin
         apply_chk("R3", 3'(k), 32'hC3A5_0F71, 32'h0, 1'b1, 32'hC3A5_0F71, 1'b1);
         apply_chk("R3", 3'(k), 32'hC3A5_0F71, 32'h0, 1'b0, 32'hC3A5_0F71, 1'b0);
      end
   endtask

   task automatic t_lsl_R4;
      apply_chk("R4", 3'd0, 32'h8000_0001, 32'd1,  1'b0, 32'h0000_0002, 1'b1);
      apply_chk("R4", 3'd0, 32'h0000_000F, 32'd4,  1'b1, 32'h0000_00F0, 1'b0);
      apply_chk("R4", 3'd0, 32'h0000_0001, 32'd32, 1'b0, 32'h0000_0000, 1'b1);
      apply_chk("R4", 3'd0, 32'hFFFF_FFFE, 32'd32, 1'b1, 32'h0000_0000, 1'b0);
   endtask

   task automatic t_lsr_R5;
      apply_chk("R5", 3'd1, 32'h8000_0003, 32'd1,  1'b0, 32'h4000_0001, 1'b1);
      apply_chk("R5", 3'd1, 32'h8000_0000, 32'd32, 1'b0, 32'h0000_0000, 1'b1);
      apply_chk("R5", 3'd1, 32'h7FFF_FFFF, 32'd32, 1'b1, 32'h0000_0000, 1'b0);
   endtask

   task automatic t_over_R6;
      apply_chk("R6", 3'd0, 32'hFFFF_FFFF, 32'd33,  1'b1, 32'h0, 1'b0);
      apply_chk("R6", 3'd1, 32'hFFFF_FFFF, 32'd255, 1'b1, 32'h0, 1'b0);
      apply_chk("R6", 3'd1, 32'hFFFF_FFFF, 32'd33,  1'b1, 32'h0, 1'b0);
   endtask

   task automatic t_asr_R7;
      apply_chk("R7", 3'd2, 32'h8000_0010, 32'd4,  1'b1, 32'hF800_0001, 1'b0);
      apply_chk("R7", 3'd2, 32'h8000_0018, 32'd4,  1'b0, 32'hF800_0001, 1'b1);
      apply_chk("R7", 3'd2, 32'h7000_0000, 32'd28, 1'b1, 32'h0000_0007, 1'b0);
      apply_chk("R7", 3'd2, 32'hC000_0000, 32'd31, 1'b0, 32'hFFFF_FFFF, 1'b1);
   endtask

   task automatic t_asr_R8;
      apply_chk("R8", 3'd2, 32'h8000_0000, 32'd32,  1'b0, 32'hFFFF_FFFF, 1'b1);
      apply_chk("R8", 3'd2, 32'h8000_0000, 32'd200, 1'b0, 32'hFFFF_FFFF, 1'b1);
      apply_chk("R8", 3'd2, 32'h7FFF_FFFF, 32'd40,  1'b1, 32'h0000_0000, 1'b0);
   endtask

   task automatic t_ror_R9;
      apply_chk("R9", 3'd3, 32'h0000_0001, 32'd1,  1'b0, 32'h8000_0000, 1'b1);
      apply_chk("R9", 3'd3, 32'h1234_5678, 32'd8,  1'b1, 32'h7812_3456, 1'b0);
      apply_chk("R9", 3'd3, 32'h8000_0000, 32'd32, 1'b0, 32'h8000_0000, 1'b1);
      apply_chk("R9", 3'd3, 32'h0000_0001, 32'd64, 1'b1, 32'h0000_0001, 1'b0);
      apply_chk("R9", 3'd3, 32'h0000_00F0, 32'd36, 1'b1, 32'h0000_000F, 1'b0);
   endtask

   task automatic t_rrx_R10;
      apply_chk("R10", 3'd4, 32'h0000_0003, 32'd0,  1'b1, 32'h8000_0001, 1'b1);
      apply_chk("R10", 3'd4, 32'h0000_0002, 32'd0,  1'b0, 32'h0000_0001, 1'b0);
      apply_chk("R10", 3'd4, 32'h0000_0003, 32'h1F, 1'b1, 32'h8000_0001, 1'b1);
   endtask

   task automatic t_spare_R11;
      for (int k = 5; k < 8; k++) begin
         apply_chk("R11", 3'(k), 32'hA5A5_A5A5, 32'd4, 1'b1, 32'hA5A5_A5A5, 1'b1);
         apply_chk("R11", 3'(k), 32'h5A5A_5A5A, 32'd0, 1'b0, 32'h5A5A_5A5A, 1'b0);
      end
   endtask

   task automatic t_amtbits_R2;
      apply_chk("R2", 3'd0, 32'h0000_0001, 32'hABCD_EF00, 1'b1, 32'h0000_0001, 1'b1);
      apply_chk("R2", 3'd0, 32'h0000_0001, 32'hFFFF_FF01, 1'b1, 32'h0000_0002, 1'b0);
      apply_chk("R2", 3'd1, 32'h8000_0000, 32'h0000_0120, 1'b0, 32'h0000_0000, 1'b1);
      apply_chk("R2", 3'd2, 32'h8000_0000, 32'h7700_0021, 1'b0, 32'hFFFF_FFFF, 1'b1);
   endtask

   task automatic t_sweep_R1;
      logic [31:0] pats [4] = '{32'hAAAA_5555, 32'h8000_0000, 32'h0000_0001, 32'h9E37_79B9};
      int extra [5] = '{63, 64, 96, 128, 255};
      for (int k = 0; k < 8; k++)
         for (int p = 0; p < 4; p++) begin
            for (int n = 0; n <= 40; n++)
               apply_ref("R1", 3'(k), pats[p], 32'(n) | 32'h5500_0000, 1'(p));
            for (int x = 0; x < 5; x++)
               apply_ref("R1", 3'(k), pats[p], 32'(extra[x]), 1'(~p));
         end
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      rst = 1'b1;
      k_i = 3'd0; d_i = '0; a_i = '0; c_i = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset();
      t_zero_R3();
      t_lsl_R4();
      t_lsr_R5();
      t_over_R6();
      t_asr_R7();
      t_asr_R8();
      t_ror_R9();
      t_rrx_R10();
      t_spare_R11();
      t_amtbits_R2();
      t_sweep_R1();
      finish_run();
   end
endmodule